// File: doc/BRIEF.md
# Power domain dependency controller

This block keeps the commanded power level of a set of separately switched domains and makes sure that no domain is turned on without the domains it depends on. The domains are one shared system domain, one domain per processor core, an optional debug domain per core, one shared debug domain, a crypto domain and one memory domain per core. Each domain is driven by a two-bit command: 00 off, 01 retention, 10 on. Each domain returns a two-bit acknowledge that reports the level it has actually reached. The block also reports an overall system level and runs the request/ready handshake for the main clock.

Each core asks for low power with a three-bit mode. The modes are run, light sleep, deep sleep with state retention, deep sleep powered off but wakeable by interrupt, and parked (powered off with interrupts ignored). A retention parameter decides whether core and system retention exist. When it is clear, a retention request leaves the core powered and is acknowledged as though it had been retained. Wake sources are per-core interrupts, a per-core software write to the core's power unit, a level-sensitive system power-up request, a crypto power request and debug power requests.

The system level is recomputed every cycle from the command registers. It is reported as 3 for system on, 2 for system retention, 1 for hibernation and 0 for all off. At reset every command is off and every core sits in the wakeable-off state.

Top module: `pwr_dep_ctrl`

## Requirements
- R1: After reset every domain command is 00, the reported system level is 0, the clock request is low and every low-power acknowledge is low.
- R2: The system level is 3 when the system command is 10, else 2 when it is 01, else 1 when any other domain command is non-zero, else 0.
- R3: A core command changes to 10 only on a clock edge at which the system command is already 10 and clock ready is high; while any core command is 10 the system command is 10. The system acknowledge may still lag behind.
- R4: A domain command changes only on an edge at which that domain's acknowledge equals its command.
- R5: Mode 3 (deep sleep, wakeable off) sets the core command to 00. An interrupt on a core in retention or in mode 3 off brings it back to 10.
- R6: With retention enabled, mode 2 sets the core command to 01. When no core is on and no other request needs the system, the system command then becomes 01.
- R7: With retention disabled, mode 2 keeps the core command at 10 and raises its acknowledge, and the system level never reaches 2.
- R8: A core parked with mode 4 ignores its interrupt. Its power-unit write wakes it only while the system command is 10.
- R9: The system power-up request alone sets the system command to 10, including when every core is parked.
- R10: The clock request is high while the system command is non-zero, while the debug domain is on, or while a wake is pending. In hibernation with no wake pending it therefore follows the debug domain.
- R11: With the per-core debug parameter set, each per-core debug command follows its request (10 or 00). With it clear, those commands stay 00 whatever the request.
- R12: A memory domain is 10 while the system command is 10. Otherwise it is 01 if its keep input is high, else 00.
- R13: The crypto command becomes 10 only on an edge where its request is high, the system command is 10 and clock ready is high. While the crypto command is not 00, the system command stays 10.
- R14: A core's low-power acknowledge is high when its command is settled and matches its mode: mode 1 on, mode 2 retention (or on without retention), mode 3 or 4 off. In mode 0 it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_lp_req | input | 3*NCORE | Per-core low-power mode (0 run, 1 sleep, 2 retention, 3 off wakeable, 4 parked) |
| core_irq | input | NCORE | Per-core interrupt wake |
| core_ppu_wr | input | NCORE | Per-core software wake write to the power unit |
| core_lp_ack | output | NCORE | Per-core low-power acknowledge |
| sys_pwr_req | input | 1 | Level system power-up request |
| dbg_pwr_req | input | 1 | Shared debug domain power request |
| crypto_pwr_req | input | 1 | Crypto domain power request |
| cdbg_pwr_req | input | NCORE | Per-core debug domain power request |
| sram_keep | input | NCORE | Keep memory contents in retention when the system is not on |
| clk_rdy | input | 1 | Main clock ready |
| clk_req | output | 1 | Main clock request |
| sys_cmd | output | 2 | System domain command |
| sys_ack | input | 2 | System domain reached level |
| core_cmd | output | 2*NCORE | Core domain commands |
| core_ack | input | 2*NCORE | Core domain reached levels |
| cdbg_cmd | output | 2*NCORE | Per-core debug domain commands |
| cdbg_ack | input | 2*NCORE | Per-core debug domain reached levels |
| dbg_cmd | output | 2 | Shared debug domain command |
| dbg_ack | input | 2 | Shared debug domain reached level |
| cry_cmd | output | 2 | Crypto domain command |
| cry_ack | input | 2 | Crypto domain reached level |
| sram_cmd | output | 2*NCORE | Memory domain commands |
| sram_ack | input | 2*NCORE | Memory domain reached levels |
| sys_state | output | 2 | System level (3 on, 2 retention, 1 hibernation, 0 off) |

## Verification
The case of interest is a core wake that arrives while the system domain's own transition is still unacknowledged. It is provoked by freezing the system acknowledge at off while a core interrupt is raised. The core must then wait until the system command reads on, and it may go on before the system acknowledge does. A later drop of the core must not move the system command until the acknowledge is released. The same bench also runs a retention-disabled copy in parallel, so every mode sweep compares both parameter variants against values worked out from the mode alone.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam logic [1:0] PW_OFF = 2'b00;
  localparam logic [1:0] PW_RET = 2'b01;
  localparam logic [1:0] PW_ON  = 2'b10;

  localparam logic [2:0] LP_RUN   = 3'd0;
  localparam logic [2:0] LP_SLEEP = 3'd1;
  localparam logic [2:0] LP_DSRET = 3'd2;
  localparam logic [2:0] LP_DSEWC = 3'd3;
  localparam logic [2:0] LP_PARK  = 3'd4;

  localparam logic [1:0] SS_OFF = 2'd0;
  localparam logic [1:0] SS_HIB = 2'd1;
  localparam logic [1:0] SS_RET = 2'd2;
  localparam logic [1:0] SS_ON  = 2'd3;

  typedef enum logic [1:0] {CS_ON, CS_RET, CS_EWC, CS_PARK} core_st_e;

  function automatic logic [1:0] sys_state_f(input logic [1:0] sysc, input logic others_live);
    if (sysc == PW_ON)       return SS_ON;
    else if (sysc == PW_RET) return SS_RET;
    else if (others_live)    return SS_HIB;
    else                     return SS_OFF;
  endfunction

  function automatic logic [1:0] sys_target_f(input logic need_on, input logic need_ret);
    if (need_on)       return PW_ON;
    else if (need_ret) return PW_RET;
    else               return PW_OFF;
  endfunction

  function automatic logic [1:0] sram_target_f(input logic [1:0] sysc, input logic keep);
    if (sysc == PW_ON) return PW_ON;
    else if (keep)     return PW_RET;
    else               return PW_OFF;
  endfunction

  function automatic logic [1:0] core_pw_f(input core_st_e st);
    case (st)
      CS_ON:   return PW_ON;
      CS_RET:  return PW_RET;
      default: return PW_OFF;
    endcase
  endfunction

  function automatic logic clk_need_f(input logic [1:0] sysc, input logic [1:0] dbgc,
                                      input logic wake);
    return (sysc != PW_OFF) || (dbgc == PW_ON) || wake;
  endfunction

  function automatic logic lp_match_f(input logic [2:0] lp, input core_st_e st, input logic ret_en);
    case (lp)
      LP_SLEEP: return st == CS_ON;
      LP_DSRET: return st == (ret_en ? CS_RET : CS_ON);
      LP_DSEWC: return st == CS_EWC;
      LP_PARK:  return st == CS_PARK;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pdc_dom_reg.sv
module pdc_dom_reg
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] want,
  input  logic [1:0] ack,
  output logic [1:0] cmd
);
  logic settled;
  assign settled = (ack == cmd);

  always_ff @(posedge clk) begin
    if (!rst_n)       cmd <= PW_OFF;
    else if (settled) cmd <= want;
  end
endmodule

// File: rtl/pdc_core_fsm.sv
module pdc_core_fsm
  import pdc_pkg::*;
#(
  parameter int RET_EN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] lp_req,
  input  logic       irq,
  input  logic       ppu_wr,
  input  logic [1:0] ack,
  input  logic       sys_on,
  input  logic       clk_rdy,
  output logic [1:0] cmd,
  output logic       lp_ack,
  output logic       wake_req,
  output logic       hold_on
);
  localparam logic RET_OK = (RET_EN != 0);

  core_st_e st_q, st_d;
  logic settled, go_ok;

  assign cmd     = core_pw_f(st_q);
  assign settled = (ack == cmd);
  assign go_ok   = sys_on && clk_rdy;

  assign wake_req = (((st_q == CS_RET) || (st_q == CS_EWC)) && irq) ||
                    ((st_q == CS_PARK) && ppu_wr && sys_on);
  assign hold_on  = (st_q == CS_ON) || wake_req;
  assign lp_ack   = settled && lp_match_f(lp_req, st_q, RET_OK);

  always_comb begin
    st_d = st_q;
    if (settled) begin
      if (st_q == CS_ON) begin
        case (lp_req)
          LP_DSRET: st_d = RET_OK ? CS_RET : CS_ON;
          LP_DSEWC: st_d = CS_EWC;
          LP_PARK:  st_d = CS_PARK;
          default:  st_d = CS_ON;
        endcase
      end else if (wake_req && go_ok) begin
        st_d = CS_ON;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= CS_EWC;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pwr_dep_ctrl.sv
module pwr_dep_ctrl
  import pdc_pkg::*;
#(
  parameter int NCORE       = 2,
  parameter int RET_EN      = 1,
  parameter int CORE_DBG_EN = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3*NCORE-1:0]   core_lp_req,
  input  logic [NCORE-1:0]     core_irq,
  input  logic [NCORE-1:0]     core_ppu_wr,
  output logic [NCORE-1:0]     core_lp_ack,
  input  logic                 sys_pwr_req,
  input  logic                 dbg_pwr_req,
  input  logic                 crypto_pwr_req,
  input  logic [NCORE-1:0]     cdbg_pwr_req,
  input  logic [NCORE-1:0]     sram_keep,
  input  logic                 clk_rdy,
  output logic                 clk_req,
  output logic [1:0]           sys_cmd,
  input  logic [1:0]           sys_ack,
  output logic [2*NCORE-1:0]   core_cmd,
  input  logic [2*NCORE-1:0]   core_ack,
  output logic [2*NCORE-1:0]   cdbg_cmd,
  input  logic [2*NCORE-1:0]   cdbg_ack,
  output logic [1:0]           dbg_cmd,
  input  logic [1:0]           dbg_ack,
  output logic [1:0]           cry_cmd,
  input  logic [1:0]           cry_ack,
  output logic [2*NCORE-1:0]   sram_cmd,
  input  logic [2*NCORE-1:0]   sram_ack,
  output logic [1:0]           sys_state
);
  localparam int CW = 2 * NCORE;

  logic [NCORE-1:0] wake_v, hold_v, ret_v;
  logic [CW-1:0]    sram_want;
  logic             sys_on, wake_any, others_live, sys_need_on;
  logic [1:0]       sys_want, cry_want, dbg_want;

  assign sys_on = (sys_cmd == PW_ON);

  for (genvar g = 0; g < NCORE; g++) begin : g_dom
    pdc_core_fsm #(.RET_EN(RET_EN)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_req   (core_lp_req[3*g +: 3]),
      .irq      (core_irq[g]),
      .ppu_wr   (core_ppu_wr[g]),
      .ack      (core_ack[2*g +: 2]),
      .sys_on   (sys_on),
      .clk_rdy  (clk_rdy),
      .cmd      (core_cmd[2*g +: 2]),
      .lp_ack   (core_lp_ack[g]),
      .wake_req (wake_v[g]),
      .hold_on  (hold_v[g])
    );
    assign ret_v[g] = (core_cmd[2*g +: 2] == PW_RET);

    assign sram_want[2*g +: 2] = sram_target_f(sys_cmd, sram_keep[g]);
    pdc_dom_reg u_sram (
      .clk (clk), .rst_n (rst_n),
      .want (sram_want[2*g +: 2]), .ack (sram_ack[2*g +: 2]), .cmd (sram_cmd[2*g +: 2])
    );

    if (CORE_DBG_EN != 0) begin : g_cdbg
      logic [1:0] cdbg_want;
      assign cdbg_want = cdbg_pwr_req[g] ? PW_ON : PW_OFF;
      pdc_dom_reg u_cdbg (
        .clk (clk), .rst_n (rst_n),
        .want (cdbg_want), .ack (cdbg_ack[2*g +: 2]), .cmd (cdbg_cmd[2*g +: 2])
      );
    end else begin : g_no_cdbg
      assign cdbg_cmd[2*g +: 2] = PW_OFF;
    end
  end

  // System domain: any live core, pending wake, crypto use or power-up request keeps it on
  assign sys_need_on = (|hold_v) || sys_pwr_req || crypto_pwr_req || (cry_cmd != PW_OFF);
  assign sys_want    = sys_target_f(sys_need_on, |ret_v);

  pdc_dom_reg u_sys (
    .clk (clk), .rst_n (rst_n), .want (sys_want), .ack (sys_ack), .cmd (sys_cmd)
  );

  assign cry_want = (crypto_pwr_req && ((cry_cmd == PW_ON) || (sys_on && clk_rdy))) ? PW_ON : PW_OFF;
  pdc_dom_reg u_cry (
    .clk (clk), .rst_n (rst_n), .want (cry_want), .ack (cry_ack), .cmd (cry_cmd)
  );

  assign dbg_want = dbg_pwr_req ? PW_ON : PW_OFF;
  pdc_dom_reg u_dbg (
    .clk (clk), .rst_n (rst_n), .want (dbg_want), .ack (dbg_ack), .cmd (dbg_cmd)
  );

  assign wake_any    = (|wake_v) || (crypto_pwr_req && (cry_cmd != PW_ON));
  assign clk_req     = clk_need_f(sys_cmd, dbg_cmd, wake_any);
  assign others_live = (|core_cmd) || (|cdbg_cmd) || (|dbg_cmd) || (|cry_cmd) || (|sram_cmd);
  assign sys_state   = sys_state_f(sys_cmd, others_live);
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk
  import pdc_pkg::*;
#(
  parameter int NCORE  = 2,
  parameter int RET_EN = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         sys_cmd,
  input logic [1:0]         sys_ack,
  input logic [2*NCORE-1:0] core_cmd,
  input logic [2*NCORE-1:0] core_ack,
  input logic [1:0]         cry_cmd,
  input logic [1:0]         dbg_cmd,
  input logic               clk_rdy,
  input logic               clk_req,
  input logic               wake_any,
  input logic [1:0]         sys_state
);
  for (genvar g = 0; g < NCORE; g++) begin : g_c
    // R3
    core_needs_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_cmd[2*g +: 2] == PW_ON) |-> (sys_cmd == PW_ON));

    // R3
    core_wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((core_cmd[2*g +: 2] != PW_ON) && !((sys_cmd == PW_ON) && clk_rdy))
      |=> (core_cmd[2*g +: 2] != PW_ON));

    // R4
    core_hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_cmd[2*g +: 2] != core_ack[2*g +: 2]) |=> $stable(core_cmd[2*g +: 2]));
  end

  // R4
  sys_hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_cmd != sys_ack) |=> $stable(sys_cmd));

  // R13
  cry_needs_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cry_cmd == PW_ON) |-> (sys_cmd == PW_ON));

  // R10
  hib_clk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sys_state == SS_HIB) && !wake_any) |-> (clk_req == (dbg_cmd == PW_ON)));

  if (RET_EN == 0) begin : g_noret
    // R7
    no_sys_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_state != SS_RET);
  end
endmodule

bind pwr_dep_ctrl pdc_chk #(.NCORE(NCORE), .RET_EN(RET_EN)) u_pdc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_cmd   (sys_cmd),
  .sys_ack   (sys_ack),
  .core_cmd  (core_cmd),
  .core_ack  (core_ack),
  .cry_cmd   (cry_cmd),
  .dbg_cmd   (dbg_cmd),
  .clk_rdy   (clk_rdy),
  .clk_req   (clk_req),
  .wake_any  (wake_any),
  .sys_state (sys_state)
);

// File: tb/pwr_dep_ctrl_bench.sv
module pwr_dep_ctrl_bench;
  localparam int N = 2;
  localparam logic [1:0] OFF = 2'b00, RET = 2'b01, ON = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3*N-1:0] lp_req = '0;
  logic [N-1:0]   irq = '0, ppu = '0, cdbg_req = '0, keep = '0;
  logic           sys_req = 1'b0, dbg_req = 1'b0, cry_req = 1'b0, freeze_sys = 1'b0;

  // instance A: retention and per-core debug enabled
  logic [N-1:0]   a_lpack;
  logic           a_clk_req, a_clk_rdy;
  logic [1:0]     a_sys, a_sys_ack, a_dbg, a_dbg_ack, a_cry, a_cry_ack, a_state;
  logic [2*N-1:0] a_core, a_core_ack, a_cdbg, a_cdbg_ack, a_sram, a_sram_ack;
  // instance B: no retention, no per-core debug
  logic [N-1:0]   b_lpack;
  logic           b_clk_req, b_clk_rdy;
  logic [1:0]     b_sys, b_sys_ack, b_dbg, b_dbg_ack, b_cry, b_cry_ack, b_state;
  logic [2*N-1:0] b_core, b_core_ack, b_cdbg, b_cdbg_ack, b_sram, b_sram_ack;

  pwr_dep_ctrl #(.NCORE(N), .RET_EN(1), .CORE_DBG_EN(1)) u_pwr_dep_ctrl (
    .clk(clk), .rst_n(rst_n), .core_lp_req(lp_req), .core_irq(irq), .core_ppu_wr(ppu),
    .core_lp_ack(a_lpack), .sys_pwr_req(sys_req), .dbg_pwr_req(dbg_req),
    .crypto_pwr_req(cry_req), .cdbg_pwr_req(cdbg_req), .sram_keep(keep),
    .clk_rdy(a_clk_rdy), .clk_req(a_clk_req), .sys_cmd(a_sys), .sys_ack(a_sys_ack),
    .core_cmd(a_core), .core_ack(a_core_ack), .cdbg_cmd(a_cdbg), .cdbg_ack(a_cdbg_ack),
    .dbg_cmd(a_dbg), .dbg_ack(a_dbg_ack), .cry_cmd(a_cry), .cry_ack(a_cry_ack),
    .sram_cmd(a_sram), .sram_ack(a_sram_ack), .sys_state(a_state));

  pwr_dep_ctrl #(.NCORE(N), .RET_EN(0), .CORE_DBG_EN(0)) u_pwr_dep_ctrl_nr (
    .clk(clk), .rst_n(rst_n), .core_lp_req(lp_req), .core_irq(irq), .core_ppu_wr(ppu),
    .core_lp_ack(b_lpack), .sys_pwr_req(sys_req), .dbg_pwr_req(dbg_req),
    .crypto_pwr_req(cry_req), .cdbg_pwr_req(cdbg_req), .sram_keep(keep),
    .clk_rdy(b_clk_rdy), .clk_req(b_clk_req), .sys_cmd(b_sys), .sys_ack(b_sys_ack),
    .core_cmd(b_core), .core_ack(b_core_ack), .cdbg_cmd(b_cdbg), .cdbg_ack(b_cdbg_ack),
    .dbg_cmd(b_dbg), .dbg_ack(b_dbg_ack), .cry_cmd(b_cry), .cry_ack(b_cry_ack),
    .sram_cmd(b_sram), .sram_ack(b_sram_ack), .sys_state(b_state));

  // Power units and clock source model: each domain reaches its command one cycle later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sys_ack <= OFF; a_dbg_ack <= OFF; a_cry_ack <= OFF; a_clk_rdy <= 1'b0;
      a_core_ack <= '0; a_cdbg_ack <= '0; a_sram_ack <= '0;
      b_sys_ack <= OFF; b_dbg_ack <= OFF; b_cry_ack <= OFF; b_clk_rdy <= 1'b0;
      b_core_ack <= '0; b_cdbg_ack <= '0; b_sram_ack <= '0;
    end else begin
      if (!freeze_sys) begin
        a_sys_ack <= a_sys;
        b_sys_ack <= b_sys;
      end
      a_dbg_ack <= a_dbg; a_cry_ack <= a_cry; a_clk_rdy <= a_clk_req;
      a_core_ack <= a_core; a_cdbg_ack <= a_cdbg; a_sram_ack <= a_sram;
      b_dbg_ack <= b_dbg; b_cry_ack <= b_cry; b_clk_rdy <= b_clk_req;
      b_core_ack <= b_core; b_cdbg_ack <= b_cdbg; b_sram_ack <= b_sram;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected core command for a mode applied to a running core
  function automatic logic [1:0] e_core(input int m, input bit ret_en);
    if (m <= 1)      return ON;
    else if (m == 2) return ret_en ? RET : ON;
    else             return OFF;
  endfunction

  // expected system level when only core0 may be live and no other domain is on
  function automatic int e_state(input logic [1:0] c);
    if (c == ON)       return 3;
    else if (c == RET) return 2;
    else               return 0;
  endfunction

  task automatic wake0;
    irq[0] = 1'b1; cyc(8); irq[0] = 1'b0; cyc(2);
  endtask

  task automatic off0;
    lp_req[2:0] = 3'd3; cyc(8); lp_req[2:0] = 3'd0; cyc(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "A sys_cmd", a_sys, 0);
    chk("R1", "A core_cmd", a_core, 0);
    chk("R1", "A sys_state", a_state, 0);
    chk("R1", "A clk_req", a_clk_req, 0);
    chk("R1", "A lp_ack", a_lpack, 0);
    chk("R1", "B sram_cmd", b_sram, 0);

    // R3: wake core0 from reset; system goes on first, core follows one edge later
    irq[0] = 1'b1;
    @(negedge clk);
    chk("R3", "A sys on first", a_sys, ON);
    chk("R3", "A core0 waits", a_core[1:0], OFF);
    @(negedge clk);
    chk("R3", "A core0 on", a_core[1:0], ON);
    chk("R3", "B core0 on", b_core[1:0], ON);
    irq[0] = 1'b0; cyc(4);
    chk("R2", "A state on", a_state, 3);
    chk("R12", "A sram on", a_sram, {ON, ON});

    // Mode sweep on core0 for both parameter variants (R5 R6 R7 R14 R2)
    for (int m = 0; m < 4; m++) begin
      lp_req[2:0] = 3'(m);
      cyc(8);
      chk("R14", $sformatf("A core0 mode%0d", m), a_core[1:0], e_core(m, 1'b1));
      chk("R7",  $sformatf("B core0 mode%0d", m), b_core[1:0], e_core(m, 1'b0));
      chk("R14", $sformatf("A lp_ack mode%0d", m), a_lpack[0], (m != 0) ? 1 : 0);
      chk("R14", $sformatf("B lp_ack mode%0d", m), b_lpack[0], (m != 0) ? 1 : 0);
      chk("R2",  $sformatf("A state mode%0d", m), a_state, e_state(e_core(m, 1'b1)));
      chk("R2",  $sformatf("B state mode%0d", m), b_state, e_state(e_core(m, 1'b0)));
      lp_req[2:0] = 3'd0;
      cyc(2);
      if (m >= 2) begin
        wake0();
        chk("R5", $sformatf("A core0 woken after mode%0d", m), a_core[1:0], ON);
      end
    end

    // R8 R9: parked core
    lp_req[2:0] = 3'd4; cyc(8); lp_req[2:0] = 3'd0; cyc(2);
    chk("R8", "A core0 parked", a_core[1:0], OFF);
    chk("R2", "A state all off", a_state, 0);
    irq[0] = 1'b1; cyc(8); irq[0] = 1'b0;
    chk("R8", "A parked ignores irq", a_core[1:0], OFF);
    chk("R8", "A clk_req idle", a_clk_req, 0);
    ppu[0] = 1'b1; cyc(8); ppu[0] = 1'b0;
    chk("R8", "A write ignored with system off", a_core[1:0], OFF);
    sys_req = 1'b1; cyc(8);
    chk("R9", "A sys on by request", a_sys, ON);
    chk("R9", "B sys on by request", b_sys, ON);
    chk("R8", "A core0 still parked", a_core[1:0], OFF);
    ppu[0] = 1'b1; @(negedge clk); ppu[0] = 1'b0; cyc(4);
    chk("R8", "A write wakes core0", a_core[1:0], ON);
    sys_req = 1'b0; cyc(4);
    chk("R3", "A core keeps sys on", a_sys, ON);

    // R4 with wake during an unacknowledged system transition
    off0();
    chk("R2", "A state off before freeze", a_state, 0);
    freeze_sys = 1'b1;
    irq[0] = 1'b1; cyc(4); irq[0] = 1'b0;
    chk("R3", "A core0 on while sys unacked", a_core[1:0], ON);
    chk("R3", "A sys ack lags", a_sys_ack, OFF);
    lp_req[2:0] = 3'd3; cyc(6);
    chk("R5", "A core0 off", a_core[1:0], OFF);
    chk("R4", "A sys held while unacked", a_sys, ON);
    chk("R4", "B sys held while unacked", b_sys, ON);
    freeze_sys = 1'b0; cyc(6);
    lp_req[2:0] = 3'd0;
    chk("R4", "A sys off after ack", a_sys, OFF);

    // R10 R12: hibernation with memory retention, debug toggled
    keep = 2'b01; cyc(6);
    chk("R12", "A sram retain/off", a_sram, {OFF, RET});
    chk("R2", "A state hibernation", a_state, 1);
    chk("R10", "A clk_req off in hibernation", a_clk_req, 0);
    dbg_req = 1'b1; cyc(6);
    chk("R10", "A clk_req with debug on", a_clk_req, 1);
    chk("R10", "B clk_req with debug on", b_clk_req, 1);
    chk("R2", "A state still hibernation", a_state, 1);
    dbg_req = 1'b0; keep = 2'b00; cyc(6);
    chk("R2", "A state off again", a_state, 0);

    // R6 R7: system retention versus fallback
    wake0();
    lp_req[2:0] = 3'd2; cyc(8);
    chk("R6", "A sys retention", a_sys, RET);
    chk("R6", "A core0 retention", a_core[1:0], RET);
    chk("R10", "A clk_req in retention", a_clk_req, 1);
    chk("R7", "B core0 stays on", b_core[1:0], ON);
    chk("R7", "B state on", b_state, 3);
    lp_req[2:0] = 3'd0; cyc(2);
    wake0();
    chk("R5", "A core0 woken from retention", a_core[1:0], ON);
    off0();

    // R13: crypto follows the system domain
    cry_req = 1'b1;
    @(negedge clk);
    chk("R13", "A sys on for crypto", a_sys, ON);
    chk("R13", "A crypto waits", a_cry, OFF);
    @(negedge clk);
    chk("R13", "A crypto on", a_cry, ON);
    cry_req = 1'b0; cyc(8);
    chk("R13", "A crypto off", a_cry, OFF);
    chk("R13", "A sys off after crypto", a_sys, OFF);

    // R11: per-core debug domains
    cdbg_req = 2'b11; cyc(6);
    chk("R11", "A cdbg on", a_cdbg, {ON, ON});
    chk("R11", "B cdbg tied off", b_cdbg, 0);
    chk("R2", "A state hibernation by cdbg", a_state, 1);
    chk("R2", "B state unaffected", b_state, 0);
    cdbg_req = 2'b00; cyc(6);
    chk("R11", "A cdbg off", a_cdbg, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule